// File: doc/BRIEF.md
# Staggered Program Issue Scheduler for a Shared Flash Bus

This block sits in a flash controller that drives four flash chips over one shared command and data bus. Each chip has its own chip-enable and its own ready/busy line. All chips also share one open-drain, active-low surge line. A chip pulls that line low while it precharges its bit lines and ramps its charge pump, which is the phase where it draws its highest current. The scheduler keeps one pending program request per chip. It issues a program strobe to a chip only when three things hold: the chip reports ready, the surge line is high, and the number of chips already busy is below a supply budget. This keeps the high-current phases of the chips from overlapping.

After each issue the scheduler opens a settle window of programmable length. During the window it issues nothing more, so the chip it just started has time to pull the surge line low before anyone else can look at the line. The window closes early as soon as the line is seen low. When several chips are eligible in the same cycle, a rotating pointer picks which one goes first. The bus command encoding and the data transfer are handled outside this block.

Top module: `ilv_prog_sched`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, prog_stb_o and ce_o are all zero.
- R2: A pulse on req_i[i] leaves chip i pending. A pending chip is issued only when rdy_i[i] is 1 (ready). A request to a busy chip stays pending until rdy_i[i] returns to 1, and the chip is then issued.
- R3: No strobe is issued while surge_ni is low. A request made during that time is issued once surge_ni is high again.
- R4: A strobe is a single-cycle, one-hot pulse on prog_stb_o. In the strobe cycle ce_o equals prog_stb_o. ce_o returns to zero when the settle window ends.
- R5: After a strobe in cycle E, with surge_ni held high, the earliest next strobe is in cycle E+W+2, where W is settle_cyc_i.
- R6: If surge_ni is seen low during the settle window, the window ends at that edge. The next strobe can then come 2 cycles after the previous one, once surge_ni is high again.
- R7: Among the chips eligible in the same cycle, the first one at or after a rotating pointer is issued. The pointer starts at chip 0 after reset and moves to the chip after the one just issued, wrapping from 3 to 0.
- R8: No strobe is issued while the number of chips with rdy_i low is MAX_BUSY or more. The default for MAX_BUSY is 2.
- R9: Several requests to the same chip made while it is pending merge into one issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_CHIPS | Program request pulse, one bit per chip |
| rdy_i | input | N_CHIPS | Ready/busy per chip, 1 = ready |
| surge_ni | input | 1 | Shared high-current line, low while a chip precharges or ramps its pump |
| settle_cyc_i | input | SETTLE_W | Settle window length in cycles |
| prog_stb_o | output | N_CHIPS | One-cycle program strobe per chip |
| ce_o | output | N_CHIPS | Chip enable, held from the strobe until the window ends |

## Verification
The stimulus covers several cases, and each one separates a different gate:
- A single request to a busy chip, which shows that the ready gate holds the request rather than dropping it.
- A request made while the surge line is low, which isolates the surge gate.
- Two chips requested together with the surge line left high, which exposes the full W+2 spacing and the pointer order.
- The same pair with a one-cycle surge pulse, which shows the early close through a gap of 2 instead of 5.
- A budget case with two chips busy, and repeated requests to one busy chip, which checks the busy cap and request merging.
- A burst on all four chips, which checks that the pointer rotates through a full cycle.

// File: rtl/ilv_sched_pkg.sv
package ilv_sched_pkg;
  typedef enum logic [0:0] {
    ST_IDLE   = 1'b0,
    ST_SETTLE = 1'b1
  } sched_st_e;
endpackage

// File: rtl/ilv_rr_pick.sv
module ilv_rr_pick #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  elig_i,
  input  logic [IW-1:0] ptr_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] gnt_idx_o,
  output logic          any_o
);
  always_comb begin
    gnt_o     = '0;
    gnt_idx_o = '0;
    any_o     = 1'b0;
    for (int k = 0; k < N; k++) begin
      int c;
      c = (int'(ptr_i) + k) % N;
      if (!any_o && elig_i[c]) begin
        any_o     = 1'b1;
        gnt_o[c]  = 1'b1;
        gnt_idx_o = IW'(c);
      end
    end
  end
endmodule

// File: rtl/ilv_busy_gate.sv
module ilv_busy_gate #(
  parameter int N        = 4,
  parameter int MAX_BUSY = 2
) (
  input  logic [N-1:0] rdy_i,
  output logic         room_o
);
  localparam int CW = $clog2(N + 1);

  generate
    if (MAX_BUSY >= N) begin : g_nocap
      // budget never binds; keep the input observed
      assign room_o = 1'b1 | (&rdy_i);
    end else begin : g_cap
      logic [CW-1:0] nbusy;
      always_comb begin
        nbusy = '0;
        for (int i = 0; i < N; i++) nbusy = nbusy + CW'(!rdy_i[i]);
      end
      assign room_o = nbusy < CW'(MAX_BUSY);
    end
  endgenerate
endmodule

// File: rtl/ilv_settle_timer.sv
module ilv_settle_timer #(
  parameter int SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [SW-1:0] settle_cyc_i,
  input  logic          surge_ni,
  input  logic          active_i,
  output logic          expire_o
);
  logic [SW-1:0] cnt_q;

  // window closes on surge seen low or count exhausted
  assign expire_o = active_i && (!surge_ni || cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (start_i)             cnt_q <= settle_cyc_i;
    else if (active_i && !expire_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/ilv_prog_sched.sv
module ilv_prog_sched
  import ilv_sched_pkg::*;
#(
  parameter int N_CHIPS  = 4,
  parameter int SETTLE_W = 8,
  parameter int MAX_BUSY = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_CHIPS-1:0]  req_i,
  input  logic [N_CHIPS-1:0]  rdy_i,
  input  logic                surge_ni,
  input  logic [SETTLE_W-1:0] settle_cyc_i,
  output logic [N_CHIPS-1:0]  prog_stb_o,
  output logic [N_CHIPS-1:0]  ce_o
);
  localparam int IW = $clog2(N_CHIPS);

  sched_st_e          st_q;
  logic [N_CHIPS-1:0] pend_q, stb_q, ce_q, elig, gnt;
  logic [IW-1:0]      ptr_q, gnt_idx;
  logic               any_gnt, room, expire, issue;

  ilv_busy_gate #(.N(N_CHIPS), .MAX_BUSY(MAX_BUSY)) u_gate (
    .rdy_i (rdy_i),
    .room_o(room)
  );

  assign elig = pend_q & rdy_i &
                {N_CHIPS{surge_ni && room && st_q == ST_IDLE}};

  ilv_rr_pick #(.N(N_CHIPS), .IW(IW)) u_pick (
    .elig_i   (elig),
    .ptr_i    (ptr_q),
    .gnt_o    (gnt),
    .gnt_idx_o(gnt_idx),
    .any_o    (any_gnt)
  );

  assign issue = any_gnt;

  ilv_settle_timer #(.SW(SETTLE_W)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (issue),
    .settle_cyc_i(settle_cyc_i),
    .surge_ni    (surge_ni),
    .active_i    (st_q == ST_SETTLE),
    .expire_o    (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pend_q <= '0;
      stb_q  <= '0;
      ce_q   <= '0;
      ptr_q  <= '0;
    end else begin
      // a fresh request re-arms even on the cycle of its issue
      pend_q <= (pend_q & ~gnt) | req_i;
      stb_q  <= gnt;
      if (issue) begin
        st_q  <= ST_SETTLE;
        ce_q  <= gnt;
        ptr_q <= (gnt_idx == IW'(N_CHIPS - 1)) ? '0 : gnt_idx + 1'b1;
      end else if (expire) begin
        st_q <= ST_IDLE;
        ce_q <= '0;
      end
    end
  end

  assign prog_stb_o = stb_q;
  assign ce_o       = ce_q;

  p_stb_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(prog_stb_o));
  p_stb_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|prog_stb_o) |=> (prog_stb_o == '0));
  p_ce_match_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|prog_stb_o) |-> (ce_o == prog_stb_o));
  p_stb_surge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|prog_stb_o) |-> $past(surge_ni));
  p_busy_cap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|prog_stb_o) |-> ($past($countones(~rdy_i)) < MAX_BUSY));
  p_settle_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|prog_stb_o) && surge_ni) |=> (prog_stb_o == '0));

  for (genvar i = 0; i < N_CHIPS; i++) begin : g_chk
    p_stb_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prog_stb_o[i] |-> $past(rdy_i[i]));
  end
endmodule

// File: tb/ilv_prog_sched_bench.sv
module ilv_prog_sched_bench;
  localparam int N = 4;
  localparam int W = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [N-1:0] req = '0, rdy = '1, stb, ce;
  logic       surge_n = 1'b1;
  logic [7:0] settle = 8'(W);

  int total = 0, bad = 0, n_stb = 0, cyc = 0, last_cyc = 0, last_gap = 0;
  int exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ilv_prog_sched u_ilv_prog_sched (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rdy_i(rdy),
    .surge_ni(surge_n), .settle_cyc_i(settle),
    .prog_stb_o(stb), .ce_o(ce)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_req(input logic [N-1:0] m);
    @(negedge clk) req = m;
    @(negedge clk) req = '0;
  endtask

  // monitor: pop expected chip per strobe
  always @(negedge clk) begin
    if (rst_n && stb != '0) begin
      int idx;
      idx = -1;
      for (int i = 0; i < N; i++) if (stb[i]) idx = i;
      chk($countones(stb) == 1 && ce == stb, "R4 strobe onehot/ce", int'(ce), int'(stb));
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected strobe", idx, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(idx == e, "R7 issue order", idx, e);
      end
      last_gap = cyc - last_cyc;
      last_cyc = cyc;
      n_stb++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    chk(stb == '0 && ce == '0, "R1 reset outputs", int'(stb | ce), 0);
    @(negedge clk) rst_n = 1'b1;
    chk(stb == '0 && ce == '0, "R1 first cycle", int'(stb | ce), 0);

    // R2: busy chip holds request
    rdy = 4'b1011;
    pulse_req(4'b0100);
    idle(6);
    chk(n_stb == 0, "R2 busy chip held", n_stb, 0);
    exp_q.push_back(2);
    rdy = 4'b1111;
    idle(4);
    chk(n_stb == 1, "R2 issued after ready", n_stb, 1);

    // R3: surge low blocks
    idle(6);
    surge_n = 1'b0;
    pulse_req(4'b0010);
    idle(6);
    chk(n_stb == 1, "R3 blocked while surge low", n_stb, 1);
    exp_q.push_back(1);
    surge_n = 1'b1;
    idle(4);
    chk(n_stb == 2, "R3 issued after surge high", n_stb, 2);

    // R5 + R7: pair, full window
    idle(8);
    exp_q.push_back(3);
    exp_q.push_back(0);
    pulse_req(4'b1001);
    idle(12);
    chk(n_stb == 4, "R7 pair issued", n_stb, 4);
    chk(last_gap == W + 2, "R5 settle spacing", last_gap, W + 2);
    chk(ce == '0, "R4 ce released", int'(ce), 0);

    // R6: early close on surge pulse
    idle(4);
    exp_q.push_back(1);
    exp_q.push_back(2);
    @(negedge clk) req = 4'b0110;
    @(negedge clk) req = '0;
    @(negedge clk) surge_n = 1'b0;
    @(negedge clk) surge_n = 1'b1;
    idle(8);
    chk(n_stb == 6, "R6 pair issued", n_stb, 6);
    chk(last_gap == 2, "R6 early close gap", last_gap, 2);

    // R8: busy budget
    rdy = 4'b0110;
    pulse_req(4'b0100);
    idle(8);
    chk(n_stb == 6, "R8 blocked at budget", n_stb, 6);
    exp_q.push_back(2);
    rdy = 4'b1110;
    idle(4);
    chk(n_stb == 7, "R8 issued under budget", n_stb, 7);

    // R9: repeated requests merge
    idle(6);
    pulse_req(4'b0001);
    idle(2);
    pulse_req(4'b0001);
    idle(4);
    chk(n_stb == 7, "R2 busy chip pending", n_stb, 7);
    exp_q.push_back(0);
    rdy = 4'b1111;
    idle(15);
    chk(n_stb == 8, "R9 merged to one issue", n_stb, 8);

    // R7: full rotation
    idle(4);
    exp_q.push_back(1);
    exp_q.push_back(2);
    exp_q.push_back(3);
    exp_q.push_back(0);
    pulse_req(4'b1111);
    idle(40);
    chk(n_stb == 12, "R7 rotation count", n_stb, 12);
    chk(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);
    chk(ce == '0, "R4 idle ce", int'(ce), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule